// File: doc/BRIEF.md
# Accumulator Compare with Guard-Bit Status Flags

This block is the compare stage of a 36-bit signal-processing data path. Each accepted operation subtracts a source operand from a destination accumulator. The difference is used only to derive status; it is never written back. From that difference the block builds seven condition flags. Four of them are the usual sign, zero, signed-overflow and borrow indications. The other three come from the guard-bit format:

- a flag that reports that the extension bits carry part of the integer value;
- a flag that reports that the result is not normalized;
- a sticky limit flag that records that an overflow has occurred.

The source can be one of four kinds: a full 36-bit accumulator, a 16-bit register or memory word, an unsigned 5-bit immediate, or a signed 16-bit immediate. Every narrow source is aligned into accumulator format before the subtraction. The upstream decoder presents both operands and a select code with a one-cycle valid strobe. The registered flags can be read on the cycle after the accepting edge. A separate clear input resets the sticky limit flag.

Top module: `acc_compare`

## Requirements
- R1: While `rst` is high at a rising edge, all seven flags become 0 after that edge.
- R2: The flags change only after an edge where `cmp_valid` is 1, apart from `flag_l`, which `flag_clr` may also change. New values are visible right after the accepting edge. With `cmp_valid` low, the operand and select inputs have no effect.
- R3: Source alignment is chosen by `src_sel`:
  - 2'b00: all 36 bits of `src_bus` are used.
  - 2'b01 (word) and 2'b11 (signed immediate): `src_bus[15:0]` goes to bits 31:16, bit 15 of that value is copied into bits 35:32, and bits 15:0 are zero. `src_bus[35:16]` is ignored.
  - 2'b10: `src_bus[4:0]` is zero-extended to 16 bits and then aligned the same way. `src_bus[35:5]` is ignored.
- R4: `flag_n` equals bit 35 of the 36-bit difference `dst_acc - source`.
- R5: `flag_z` is 1 exactly when all 36 bits of the difference are zero.
- R6: `flag_v` is 1 when the signed 36-bit subtraction overflows, that is, when the operands differ in sign and the sign of the difference differs from the sign of `dst_acc`.
- R7: `flag_c` is 1 when the subtraction borrows out of bit 35, that is, when `dst_acc` is below the aligned source taken as unsigned 36-bit values.
- R8: `flag_e` is 1 when bits 35 down to 31 of the difference are not all equal.
- R9: `flag_u` is 1 when bit 31 of the difference equals bit 30.
- R10: `flag_l` becomes 1 after an accepted compare that sets `flag_v`. It then stays 1 through later compares, with or without overflow, until it is cleared.
- R11: `flag_clr` clears `flag_l` at the next edge. If the same edge also accepts a compare that overflows, `flag_l` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Accept a compare at this edge |
| flag_clr | input | 1 | Clear the sticky limit flag |
| dst_acc | input | 36 | Destination accumulator operand |
| src_bus | input | 36 | Source operand, interpreted per `src_sel` |
| src_sel | input | 2 | Source kind: 00 accumulator, 01 word, 10 unsigned 5-bit immediate, 11 signed 16-bit immediate |
| flag_l | output | 1 | Sticky limit (overflow occurred) |
| flag_e | output | 1 | Extension portion in use |
| flag_u | output | 1 | Unnormalized result |
| flag_n | output | 1 | Negative (bit 35) |
| flag_z | output | 1 | Zero result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Borrow out of bit 35 |

## Verification
The assertions check the properties that must hold on every cycle:
- flags hold when no compare is accepted;
- the limit flag stays set until a clear;
- a clear with no compare empties the limit flag;
- a rising overflow flag always comes with the limit flag set;
- a zero result implies the fixed values of the other flags;
- comparing an accumulator with an identical one gives zero with no borrow.

Only the bench scenarios can show that each flag has the right value for a given pair of operands. The same holds for the alignment and extension of each source kind, for the ignored upper source bits, and for a clear that lands on the same edge as an overflowing compare.

// File: rtl/acc_compare_pkg.sv
package acc_compare_pkg;

  typedef enum logic [1:0] {
    SRC_ACC   = 2'b00,
    SRC_WORD  = 2'b01,
    SRC_UIMM5 = 2'b10,
    SRC_SIMM  = 2'b11
  } src_kind_e;

  typedef struct packed {
    logic l;
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/acc_src_align.sv
module acc_src_align
  import acc_compare_pkg::*;
#(
  parameter int ACC_W  = 36,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic [ACC_W-1:0] src_bus,
  input  src_kind_e        kind,
  output logic [ACC_W-1:0] src_aligned
);
  localparam int EXT_W = ACC_W - WORD_W - FRAC_W;

  logic [WORD_W-1:0] word_val;

  always_comb begin
    if (kind == SRC_UIMM5)
      word_val = {{(WORD_W-IMM_W){1'b0}}, src_bus[IMM_W-1:0]};
    else
      word_val = src_bus[WORD_W-1:0];
  end

  always_comb begin
    if (kind == SRC_ACC)
      src_aligned = src_bus;
    else
      src_aligned = {{EXT_W{word_val[WORD_W-1]}}, word_val, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/acc_flag_calc.sv
module acc_flag_calc
  import acc_compare_pkg::*;
#(
  parameter int ACC_W  = 36,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic [ACC_W-1:0] dst,
  input  logic [ACC_W-1:0] src,
  output logic             f_e,
  output logic             f_u,
  output logic             f_n,
  output logic             f_z,
  output logic             f_v,
  output logic             f_c
);
  localparam int MSB     = ACC_W - 1;
  localparam int INT_LSB = FRAC_W + WORD_W - 1;
  localparam int EXT_CNT = MSB - INT_LSB;

  logic [ACC_W:0]   wide;
  logic [ACC_W-1:0] diff;
  logic [EXT_CNT-1:0] ext_match;

  assign wide = {1'b0, dst} - {1'b0, src};
  assign diff = wide[ACC_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < EXT_CNT; gi++) begin : g_ext
      assign ext_match[gi] = (diff[INT_LSB+1+gi] == diff[INT_LSB]);
    end
  endgenerate

  always_comb begin
    f_c = wide[ACC_W];
    f_n = diff[MSB];
    f_z = (diff == '0);
    f_v = (dst[MSB] != src[MSB]) && (diff[MSB] != dst[MSB]);
    f_e = !(&ext_match);
    f_u = (diff[INT_LSB] == diff[INT_LSB-1]);
  end
endmodule

// File: rtl/acc_compare.sv
module acc_compare
  import acc_compare_pkg::*;
#(
  parameter int ACC_W  = 36,
  parameter int WORD_W = 16,
  parameter int FRAC_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic             flag_clr,
  input  logic [ACC_W-1:0] dst_acc,
  input  logic [ACC_W-1:0] src_bus,
  input  logic [1:0]       src_sel,
  output logic             flag_l,
  output logic             flag_e,
  output logic             flag_u,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);
  logic [ACC_W-1:0] src_aligned;
  ccr_t             ccr_q;
  ccr_t             ccr_new;
  logic             limit_next;

  acc_src_align #(
    .ACC_W(ACC_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W), .IMM_W(IMM_W)
  ) u_align (
    .src_bus     (src_bus),
    .kind        (src_kind_e'(src_sel)),
    .src_aligned (src_aligned)
  );

  acc_flag_calc #(
    .ACC_W(ACC_W), .WORD_W(WORD_W), .FRAC_W(FRAC_W)
  ) u_calc (
    .dst (dst_acc),
    .src (src_aligned),
    .f_e (ccr_new.e),
    .f_u (ccr_new.u),
    .f_n (ccr_new.n),
    .f_z (ccr_new.z),
    .f_v (ccr_new.v),
    .f_c (ccr_new.c)
  );

  // clear drops the old limit state; an overflow on the same edge still sets it
  assign limit_next = (flag_clr ? 1'b0 : ccr_q.l) | (cmp_valid & ccr_new.v);
  assign ccr_new.l  = limit_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_q <= '0;
    end else begin
      ccr_q.l <= limit_next;
      if (cmp_valid) begin
        ccr_q.e <= ccr_new.e;
        ccr_q.u <= ccr_new.u;
        ccr_q.n <= ccr_new.n;
        ccr_q.z <= ccr_new.z;
        ccr_q.v <= ccr_new.v;
        ccr_q.c <= ccr_new.c;
      end
    end
  end

  assign flag_l = ccr_q.l;
  assign flag_e = ccr_q.e;
  assign flag_u = ccr_q.u;
  assign flag_n = ccr_q.n;
  assign flag_z = ccr_q.z;
  assign flag_v = ccr_q.v;
  assign flag_c = ccr_q.c;
endmodule

// File: rtl/acc_compare_chk.sv
module acc_compare_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_valid,
  input logic             flag_clr,
  input logic [ACC_W-1:0] dst_acc,
  input logic [ACC_W-1:0] src_bus,
  input logic [1:0]       src_sel,
  input logic             flag_l,
  input logic             flag_e,
  input logic             flag_u,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !(flag_l | flag_e | flag_u | flag_n | flag_z | flag_v | flag_c)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable({flag_e, flag_u, flag_n, flag_z, flag_v, flag_c})); // R2

  AST_LIMIT_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_l && !flag_clr |=> flag_l); // R10

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !cmp_valid |=> !flag_l); // R11

  AST_OVF_MARKS_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_v) |-> flag_l); // R6

  AST_ZERO_SHAPE: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> (flag_u && !flag_n && !flag_e && !flag_v && !flag_c)); // R5

  AST_SELF_EQUAL: assert property (@(posedge clk) disable iff (rst)
    cmp_valid && src_sel == 2'b00 && dst_acc == src_bus |=> flag_z && !flag_c); // R7
endmodule

bind acc_compare acc_compare_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .flag_clr(flag_clr),
  .dst_acc(dst_acc), .src_bus(src_bus), .src_sel(src_sel),
  .flag_l(flag_l), .flag_e(flag_e), .flag_u(flag_u), .flag_n(flag_n),
  .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/tb_acc_compare.sv
`timescale 1ns/1ps
module tb_acc_compare;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic        flag_clr = 1'b0;
  logic [35:0] dst_acc = '0;
  logic [35:0] src_bus = '0;
  logic [1:0]  src_sel = 2'b00;
  logic flag_l, flag_e, flag_u, flag_n, flag_z, flag_v, flag_c;

  always #2.5 clk = ~clk;

  acc_compare dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .flag_clr(flag_clr),
    .dst_acc(dst_acc), .src_bus(src_bus), .src_sel(src_sel),
    .flag_l(flag_l), .flag_e(flag_e), .flag_u(flag_u), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  typedef struct {
    logic [6:0] flags;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         total = 0;
  int         bad = 0;
  logic [6:0] model = '0;   // {l,e,u,n,z,v,c}
  bit         done = 0;

  function automatic logic [6:0] outs();
    return {flag_l, flag_e, flag_u, flag_n, flag_z, flag_v, flag_c};
  endfunction

  function automatic logic [35:0] align(logic [35:0] raw, logic [1:0] sel);
    logic [15:0] w;
    if (sel == 2'b00) return raw;
    w = (sel == 2'b10) ? {11'd0, raw[4:0]} : raw[15:0];
    return {{4{w[15]}}, w, 16'h0000};
  endfunction

  function automatic logic [6:0] predict(logic [35:0] d, logic [35:0] raw,
                                         logic [1:0] sel, logic clr, logic [6:0] prev);
    logic [35:0] s, r;
    logic [36:0] w;
    logic e, u, n, z, v, c, l;
    s = align(raw, sel);
    w = {1'b0, d} - {1'b0, s};
    r = w[35:0];
    c = w[36];
    n = r[35];
    z = (r == 36'd0);
    v = (d[35] != s[35]) && (r[35] != d[35]);
    e = !(r[35:31] == 5'b00000 || r[35:31] == 5'b11111);
    u = (r[31] == r[30]);
    l = (clr ? 1'b0 : prev[6]) | v;
    return {l, e, u, n, z, v, c};
  endfunction

  task automatic check(logic [6:0] act, logic [6:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: flags{l,e,u,n,z,v,c} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one accepted compare, expected item into the scoreboard
  task automatic drive(logic [35:0] d, logic [35:0] raw, logic [1:0] sel,
                       logic clr, string tag);
    exp_t it;
    @(negedge clk);
    dst_acc = d; src_bus = raw; src_sel = sel; flag_clr = clr; cmp_valid = 1'b1;
    model = predict(d, raw, sel, clr, model);
    it.flags = model;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    cmp_valid = 1'b0; flag_clr = 1'b0;
  endtask

  // monitor: pops one item per accepted compare
  initial begin
    forever begin
      @(posedge clk);
      if (cmp_valid && !rst) begin
        #1;
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2: result with empty scoreboard actual=%b expected=none", outs());
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check(outs(), it.flags, it.tag);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [6:0] snap;
    dst_acc = 36'hF_FFFF_FFFF; src_bus = 36'h1; src_sel = 2'b00; cmp_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(outs(), 7'b0, "R1 reset");
    cmp_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(outs(), 7'b0, "R2 valid low after reset");

    drive(36'h1_2345_6789, 36'h1_2345_6789, 2'b00, 0, "R5 equal accumulators");
    drive(36'h0, 36'h1, 2'b00, 0, "R4 R7 negative with borrow");
    drive(36'h0_8000_0000, 36'h0, 2'b00, 0, "R8 R9 extension in use");
    drive(36'h0_2000_0000, 36'h0, 2'b00, 0, "R9 unnormalized");
    drive(36'h7_FFFF_FFFF, 36'hF_FFFF_FFFF, 2'b00, 0, "R6 R10 overflow");
    drive(36'h0_0001_0000, 36'h0, 2'b00, 0, "R10 sticky after clean compare");

    // inputs move with valid low: nothing changes
    snap = outs();
    @(negedge clk);
    dst_acc = 36'h8_0000_0000; src_bus = 36'h7_FFFF_FFFF; src_sel = 2'b11;
    repeat (2) @(negedge clk);
    check(outs(), snap, "R2 idle inputs ignored");

    // clear alone
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    model[6] = 1'b0;
    check(outs(), model, "R11 clear alone");

    drive(36'h0_0005_0000, 36'hA_BCDE_0005, 2'b01, 0, "R3 word upper bits ignored");
    drive(36'h0_001F_0000, 36'hF_FFFF_FFFF, 2'b10, 0, "R3 uimm5 upper bits ignored");
    drive(36'h0_0000_0000, 36'h0_0000_8000, 2'b11, 0, "R3 simm negative extended");
    drive(36'h0_0003_0000, 36'h0_0000_0004, 2'b10, 0, "R3 R7 uimm5 borrow");
    drive(36'h8_0000_0000, 36'h0_0000_0001, 2'b01, 0, "R6 overflow sets limit");
    drive(36'h0, 36'h0, 2'b00, 1, "R11 clear with clean compare");
    drive(36'h8_0000_0000, 36'h0_0000_0001, 2'b11, 1, "R11 clear with overflow");

    for (int i = 0; i < 60; i++) begin
      logic [35:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      drive(a, b, 2'(i % 4), (i % 7) == 0, "R4 R5 R6 R7 R8 R9 R10 random");
    end

    repeat (3) @(negedge clk);
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R2: scoreboard left actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule